// File: doc/BRIEF.md
# Three-Stage Instruction Fetch Front End

This block is the front of a small in-order core. It holds three slots: fetch, decode and execute. It reads 32-bit instruction words from a synchronous instruction memory, which returns each word one cycle after the address is presented. The block hands one instruction per cycle to the execute side. Each instruction comes with its own byte address and with an operand PC value. That value is always the instruction's own address plus 8. The offset is an architectural constant: it holds after a redirect and while the pipe is refilling, even when the fetch address is not two words ahead.

The execute side decides branches and reports a taken branch through `br_taken_i` and `br_target_i`, in the same cycle as the instruction in execute. The block then restarts fetch at the target and discards younger work. In normal mode both younger instructions are discarded. With `ds_mode_i` high, the instruction right behind the branch completes as a delay slot, and only the one behind it is discarded. A stall input freezes every slot and the fetch address.

A flow state machine tracks which slots hold live instructions. It has four states:
- `ST_EMPTY`: decode and execute are both empty.
- `ST_PRIME`: only decode is live.
- `ST_STREAM`: both are live.
- `ST_SLOT`: execute holds a delay-slot instruction and decode is empty.

Its transitions:
- fill: `ST_EMPTY` to `ST_PRIME`, then `ST_PRIME` to `ST_STREAM`.
- full flush: `ST_STREAM` to `ST_EMPTY`, on a taken branch in normal mode.
- slot keep: `ST_STREAM` to `ST_SLOT`, on a taken branch in delay mode.
- slot drain: `ST_SLOT` to `ST_PRIME`, with no branch.
- slot redirect: `ST_SLOT` to `ST_EMPTY`, on a taken branch from the slot instruction.
- hold: any state stays where it is while stalled.

Top module: `fe_pipe_front`

## Requirements
- R1: While reset is low, `imem_addr_o` is 0x00000000 and `ex_valid_o` is 0. After release, address 0 first appears in execute after the second rising edge, and `imem_addr_o` reads 0x00000008 at that point.
- R2: On straight-line code, execute addresses step by 4 with one instruction per cycle. While address A is valid in execute with a live decode slot, `imem_addr_o` equals A+8.
- R3: Whenever `ex_valid_o` is 1, `ex_pc_operand_o` equals `ex_addr_o` + 8, including the cycles just after a redirect.
- R4: `ex_instr_o` is the memory word returned for `ex_addr_o`, given memory data that arrives one cycle after its address.
- R5: While `stall_i` is 1, `imem_addr_o`, `ex_valid_o`, `ex_addr_o` and `ex_instr_o` keep their values, and no instruction is lost or repeated when the stall ends.
- R6: In normal mode (`ds_mode_i`=0), a taken branch at A loads the target into `imem_addr_o` on the next edge. Execute is then empty for two cycles, so the target executes 3 cycles after A, and A+4 never executes.
- R7: In delay mode (`ds_mode_i`=1), A+4 executes in the cycle after the branch at A. The target executes 2 cycles after A+4, and A+8 never executes.
- R8: In delay mode, a taken branch signalled by the delay-slot instruction is accepted. The first target is discarded and the second target follows.
- R9: `br_taken_i` has no effect while `ex_valid_o` is 0 or `stall_i` is 1. A branch held through a stall takes effect on the first unstalled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | Freeze all slots and the fetch address |
| ds_mode_i | input | 1 | 1: keep one delay-slot instruction after a taken branch |
| br_taken_i | input | 1 | The instruction in execute is a taken branch |
| br_target_i | input | 32 | Byte address of the branch target |
| imem_addr_o | output | 32 | Instruction memory read address (fetch slot) |
| imem_rdata_i | input | 32 | Word read from the address given one cycle earlier |
| ex_valid_o | output | 1 | Execute slot holds a live instruction |
| ex_instr_o | output | 32 | Instruction word in execute |
| ex_addr_o | output | 32 | Byte address of the instruction in execute |
| ex_pc_operand_o | output | 32 | Operand PC value: `ex_addr_o` + 8 |

## Verification
A wrong flow state shows at the ports one edge later. A dropped or extra bubble shifts the cycle in which a branch target reaches execute. A lost slot makes an expected address missing from the executed stream. A kept slot adds one that must never run. A fault in the stall capture of the decode word gives a mismatched `ex_instr_o` on the first instruction to leave a stall, on the edge after the stall ends. An operand PC taken from the fetch address instead of the instruction's own address goes wrong in the first cycle after any redirect.

// File: rtl/fe_pkg.sv
package fe_pkg;

    // Flow states: which of decode / execute hold live instructions.
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,   // decode dead, execute dead
        ST_PRIME  = 2'd1,   // decode live, execute dead
        ST_STREAM = 2'd2,   // decode live, execute live
        ST_SLOT   = 2'd3    // decode dead, execute holds delay-slot instruction
    } flow_state_e;

    typedef struct packed {
        logic dec_live;
        logic ex_live;
    } slot_live_t;

endpackage

// File: rtl/fe_flow_ctrl.sv
module fe_flow_ctrl
    import fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic ds_mode,
    input  logic br_taken,
    output logic advance,
    output logic redirect,
    output logic dec_valid,
    output logic ex_valid
);

    flow_state_e state_q;
    flow_state_e state_d;
    slot_live_t  live;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        live = '0;
        unique case (state_q)
            ST_EMPTY:  live = '{dec_live: 1'b0, ex_live: 1'b0};
            ST_PRIME:  live = '{dec_live: 1'b1, ex_live: 1'b0};
            ST_STREAM: live = '{dec_live: 1'b1, ex_live: 1'b1};
            ST_SLOT:   live = '{dec_live: 1'b0, ex_live: 1'b1};
            default:   live = '0;
        endcase
    end

    assign dec_valid = live.dec_live;
    assign ex_valid  = live.ex_live;
    assign advance   = !stall;
    assign redirect  = br_taken && live.ex_live && !stall;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!stall) begin
            unique case (state_q)
                ST_EMPTY:  state_d = ST_PRIME;
                ST_PRIME:  state_d = ST_STREAM;
                ST_STREAM: begin
                    if (redirect) begin
                        state_d = ds_mode ? ST_SLOT : ST_EMPTY;
                    end else begin
                        state_d = ST_STREAM;
                    end
                end
                ST_SLOT:   state_d = redirect ? ST_EMPTY : ST_PRIME;
                default:   state_d = ST_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/fe_fetch_unit.sv
module fe_fetch_unit #(
    parameter int unsigned     ADDR_W      = 32,
    parameter int unsigned     STEP_BYTES  = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        pc_d = pc_q;
        if (advance) begin
            pc_d = redirect ? target : (pc_q + STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_ADDR;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign fetch_addr = pc_q;

endmodule

// File: rtl/fe_decode_latch.sv
module fe_decode_latch #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic [INSTR_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]  dec_addr,
    output logic [INSTR_W-1:0] dec_instr
);

    // The memory word for the decode slot arrives in the decode cycle.
    // When a stall starts, the word is parked here because the memory
    // keeps reading the frozen fetch address.
    logic [ADDR_W-1:0]  addr_q;
    logic [INSTR_W-1:0] park_q;
    logic               parked_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            park_q   <= '0;
            parked_q <= 1'b0;
        end else if (advance) begin
            addr_q   <= fetch_addr;
            parked_q <= 1'b0;
        end else if (!parked_q) begin
            park_q   <= mem_rdata;
            parked_q <= 1'b1;
        end
    end

    assign dec_addr  = addr_q;
    assign dec_instr = parked_q ? park_q : mem_rdata;

endmodule

// File: rtl/fe_exec_slot.sv
module fe_exec_slot #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned INSTR_W   = 32,
    parameter int unsigned PC_OFFSET = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [ADDR_W-1:0]  dec_addr,
    input  logic [INSTR_W-1:0] dec_instr,
    output logic [ADDR_W-1:0]  ex_addr,
    output logic [INSTR_W-1:0] ex_instr,
    output logic [ADDR_W-1:0]  ex_operand
);

    localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(PC_OFFSET);

    logic [ADDR_W-1:0]  addr_q;
    logic [INSTR_W-1:0] instr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            instr_q <= '0;
        end else if (advance) begin
            addr_q  <= dec_addr;
            instr_q <= dec_instr;
        end
    end

    assign ex_addr    = addr_q;
    assign ex_instr   = instr_q;
    assign ex_operand = addr_q + OFFSET;

endmodule

// File: rtl/fe_pipe_front.sv
module fe_pipe_front #(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       INSTR_W     = 32,
    parameter int unsigned       INSTR_BYTES = 4,
    parameter int unsigned       PC_LEAD     = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic               ds_mode_i,
    input  logic               br_taken_i,
    input  logic [ADDR_W-1:0]  br_target_i,
    output logic [ADDR_W-1:0]  imem_addr_o,
    input  logic [INSTR_W-1:0] imem_rdata_i,
    output logic               ex_valid_o,
    output logic [INSTR_W-1:0] ex_instr_o,
    output logic [ADDR_W-1:0]  ex_addr_o,
    output logic [ADDR_W-1:0]  ex_pc_operand_o
);

    localparam int unsigned PC_OFFSET = PC_LEAD * INSTR_BYTES;

    logic               advance;
    logic               redirect;
    logic               dec_valid;
    logic               ex_valid;
    logic [ADDR_W-1:0]  fetch_addr;
    logic [ADDR_W-1:0]  dec_addr;
    logic [INSTR_W-1:0] dec_instr;

    fe_flow_ctrl u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall_i),
        .ds_mode   (ds_mode_i),
        .br_taken  (br_taken_i),
        .advance   (advance),
        .redirect  (redirect),
        .dec_valid (dec_valid),
        .ex_valid  (ex_valid)
    );

    fe_fetch_unit #(
        .ADDR_W     (ADDR_W),
        .STEP_BYTES (INSTR_BYTES),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .redirect   (redirect),
        .target     (br_target_i),
        .fetch_addr (fetch_addr)
    );

    fe_decode_latch #(
        .ADDR_W  (ADDR_W),
        .INSTR_W (INSTR_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .fetch_addr (fetch_addr),
        .mem_rdata  (imem_rdata_i),
        .dec_addr   (dec_addr),
        .dec_instr  (dec_instr)
    );

    fe_exec_slot #(
        .ADDR_W    (ADDR_W),
        .INSTR_W   (INSTR_W),
        .PC_OFFSET (PC_OFFSET)
    ) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .dec_addr   (dec_addr),
        .dec_instr  (dec_instr),
        .ex_addr    (ex_addr_o),
        .ex_instr   (ex_instr_o),
        .ex_operand (ex_pc_operand_o)
    );

    assign imem_addr_o = fetch_addr;
    assign ex_valid_o  = ex_valid;

endmodule

// File: rtl/fe_pipe_front_chk.sv
module fe_pipe_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stall_i,
    input logic        ds_mode_i,
    input logic        br_taken_i,
    input logic [31:0] br_target_i,
    input logic [31:0] imem_addr_o,
    input logic        ex_valid_o,
    input logic [31:0] ex_instr_o,
    input logic [31:0] ex_addr_o,
    input logic [31:0] ex_pc_operand_o,
    input logic        dec_valid
);

    // R2: fetch runs two words ahead of a streaming execute slot
    a_r2_fetch_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_o && dec_valid) |-> (imem_addr_o == ex_addr_o + 32'd8));

    // R2: straight-line progress by one word per cycle
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_o && dec_valid && !br_taken_i && !stall_i)
        |=> (ex_valid_o && ex_addr_o == $past(ex_addr_o) + 32'd4));

    // R3: operand PC agrees with the fetch address while streaming
    a_r3_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_o && dec_valid) |-> (ex_pc_operand_o == imem_addr_o));

    // R5: stall freezes fetch and execute
    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(imem_addr_o) && $stable(ex_valid_o)
                     && $stable(ex_addr_o) && $stable(ex_instr_o)));

    // R6: taken branch loads target into fetch
    a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_o && br_taken_i && !stall_i) |=> (imem_addr_o == $past(br_target_i)));

    // R6: normal mode empties execute after a taken branch
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_o && br_taken_i && !stall_i && !ds_mode_i) |=> !ex_valid_o);

    // R7: delay mode keeps the next sequential instruction
    a_r7_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_o && dec_valid && br_taken_i && !stall_i && ds_mode_i)
        |=> (ex_valid_o && ex_addr_o == $past(ex_addr_o) + 32'd4));

    // R9: branch without a live execute slot leaves fetch sequential
    a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid_o && !stall_i) |=> (imem_addr_o == $past(imem_addr_o) + 32'd4));

endmodule

bind fe_pipe_front fe_pipe_front_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stall_i         (stall_i),
    .ds_mode_i       (ds_mode_i),
    .br_taken_i      (br_taken_i),
    .br_target_i     (br_target_i),
    .imem_addr_o     (imem_addr_o),
    .ex_valid_o      (ex_valid_o),
    .ex_instr_o      (ex_instr_o),
    .ex_addr_o       (ex_addr_o),
    .ex_pc_operand_o (ex_pc_operand_o),
    .dec_valid       (dec_valid)
);

// File: tb/fe_pipe_front_test.sv
`timescale 1ns/1ps
module fe_pipe_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        ds_mode = 1'b0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata = '0;
    logic        ex_valid;
    logic [31:0] ex_instr;
    logic [31:0] ex_addr;
    logic [31:0] ex_operand;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Branch table used by the execute-side model
    logic [31:0] bsrc [0:1];
    logic [31:0] bdst [0:1];
    bit          noise = 1'b0;

    // Log of retired instructions
    logic [31:0] log_addr [0:63];
    int          log_cyc  [0:63];
    int          log_n = 0;
    int          cyc = 0;

    logic [31:0] exp_a [0:7];
    int          exp_n = 0;

    always #5 clk = ~clk;

    fe_pipe_front uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .stall_i         (stall),
        .ds_mode_i       (ds_mode),
        .br_taken_i      (br_taken),
        .br_target_i     (br_target),
        .imem_addr_o     (imem_addr),
        .imem_rdata_i    (imem_rdata),
        .ex_valid_o      (ex_valid),
        .ex_instr_o      (ex_instr),
        .ex_addr_o       (ex_addr),
        .ex_pc_operand_o (ex_operand)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    // Memory: one-cycle read latency
    always @(posedge clk) imem_rdata <= word_of(imem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Execute-side model and retire monitor, away from the rising edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && ex_valid && !stall) begin
            chk(ex_instr == word_of(ex_addr), "R4", "instr word", ex_instr, word_of(ex_addr));
            chk(ex_operand == ex_addr + 32'd8, "R3", "pc operand", ex_operand, ex_addr + 32'd8);
            if (log_n < 64) begin
                log_addr[log_n] = ex_addr;
                log_cyc[log_n]  = cyc;
                log_n++;
            end
        end
        if (ex_valid && ex_addr == bsrc[0]) begin
            br_taken = 1'b1; br_target = bdst[0];
        end else if (ex_valid && ex_addr == bsrc[1]) begin
            br_taken = 1'b1; br_target = bdst[1];
        end else if (noise && !ex_valid) begin
            br_taken = 1'b1; br_target = 32'h0000_0300;
        end else begin
            br_taken = 1'b0; br_target = 32'h0;
        end
    end

    task automatic start(input bit mode, input logic [31:0] s0, input logic [31:0] d0,
                         input logic [31:0] s1, input logic [31:0] d1, input bit nz);
        @(posedge clk); #1;
        rst_n = 1'b0; stall = 1'b0;
        ds_mode = mode; noise = nz;
        bsrc[0] = s0; bdst[0] = d0; bsrc[1] = s1; bdst[1] = d1;
        repeat (2) @(posedge clk);
        #1;
        log_n = 0;
        rst_n = 1'b1;
    endtask

    function automatic int find_cyc(input logic [31:0] a);
        for (int i = 0; i < log_n; i++) if (log_addr[i] == a) return log_cyc[i];
        return -1000;
    endfunction

    task automatic compare_log(input string req);
        chk(log_n >= exp_n, req, "retire count", 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            chk(log_addr[i] == exp_a[i], req, $sformatf("stream[%0d]", i), log_addr[i], exp_a[i]);
        end
    endtask

    localparam logic [31:0] NONE = 32'hFFFF_FFF0;

    // R1: reset state and first arrival
    task automatic t_reset;
        start(1'b0, NONE, 0, NONE, 0, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(imem_addr == 32'h0, "R1", "fetch addr in reset", imem_addr, 32'h0);
        chk(!ex_valid, "R1", "ex_valid in reset", 32'(ex_valid), 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!ex_valid, "R1", "ex_valid after 1 edge", 32'(ex_valid), 32'h0);
        chk(imem_addr == 32'h4, "R1", "fetch after 1 edge", imem_addr, 32'h4);
        @(posedge clk); #1;
        chk(ex_valid && ex_addr == 32'h0, "R1", "first execute", ex_addr, 32'h0);
        chk(imem_addr == 32'h8, "R1", "fetch at first execute", imem_addr, 32'h8);
    endtask

    // R2: straight-line stream
    task automatic t_straight;
        start(1'b0, NONE, 0, NONE, 0, 1'b0);
        repeat (5) @(posedge clk);
        #1;
        chk(imem_addr == ex_addr + 32'd8, "R2", "fetch lead", imem_addr, ex_addr + 32'd8);
        repeat (7) @(posedge clk);
        exp_n = 8;
        for (int i = 0; i < 8; i++) exp_a[i] = 32'(4 * i);
        compare_log("R2");
        for (int i = 1; i < 8; i++)
            chk(log_cyc[i] == log_cyc[i-1] + 1, "R2", "one per cycle",
                32'(log_cyc[i] - log_cyc[i-1]), 32'd1);
    endtask

    // R6: normal-mode full flush
    task automatic t_normal_branch;
        start(1'b0, 32'h8, 32'h100, NONE, 0, 1'b0);
        repeat (10) @(posedge clk);
        exp_n = 6;
        exp_a[0] = 32'h0; exp_a[1] = 32'h4; exp_a[2] = 32'h8;
        exp_a[3] = 32'h100; exp_a[4] = 32'h104; exp_a[5] = 32'h108;
        compare_log("R6");
        chk(find_cyc(32'h100) - find_cyc(32'h8) == 3, "R6", "target gap",
            32'(find_cyc(32'h100) - find_cyc(32'h8)), 32'd3);
    endtask

    // R7: delay-slot mode
    task automatic t_delay_branch;
        start(1'b1, 32'h8, 32'h100, NONE, 0, 1'b0);
        repeat (10) @(posedge clk);
        exp_n = 6;
        exp_a[0] = 32'h0; exp_a[1] = 32'h4; exp_a[2] = 32'h8;
        exp_a[3] = 32'hC; exp_a[4] = 32'h100; exp_a[5] = 32'h104;
        compare_log("R7");
        chk(find_cyc(32'hC) - find_cyc(32'h8) == 1, "R7", "slot gap",
            32'(find_cyc(32'hC) - find_cyc(32'h8)), 32'd1);
        chk(find_cyc(32'h100) - find_cyc(32'hC) == 2, "R7", "target gap",
            32'(find_cyc(32'h100) - find_cyc(32'hC)), 32'd2);
    endtask

    // R8: branch in a delay slot, and the same program in normal mode
    task automatic t_slot_branch;
        start(1'b1, 32'h8, 32'h100, 32'hC, 32'h200, 1'b0);
        repeat (10) @(posedge clk);
        exp_n = 6;
        exp_a[0] = 32'h0; exp_a[1] = 32'h4; exp_a[2] = 32'h8;
        exp_a[3] = 32'hC; exp_a[4] = 32'h200; exp_a[5] = 32'h204;
        compare_log("R8");
        start(1'b0, 32'h8, 32'h100, 32'hC, 32'h200, 1'b0);
        repeat (10) @(posedge clk);
        exp_n = 5;
        exp_a[3] = 32'h100; exp_a[4] = 32'h104;
        compare_log("R8");
    endtask

    // R5: stall while streaming
    task automatic t_stall;
        logic [31:0] fa, ea, ei;
        start(1'b0, NONE, 0, NONE, 0, 1'b0);
        repeat (5) @(posedge clk);
        #1;
        stall = 1'b1;
        fa = imem_addr; ea = ex_addr; ei = ex_instr;
        repeat (3) begin
            @(posedge clk); #1;
            chk(imem_addr == fa, "R5", "fetch frozen", imem_addr, fa);
            chk(ex_addr == ea, "R5", "ex addr frozen", ex_addr, ea);
            chk(ex_instr == ei, "R5", "ex instr frozen", ex_instr, ei);
        end
        stall = 1'b0;
        repeat (6) @(posedge clk);
        exp_n = 8;
        for (int i = 0; i < 8; i++) exp_a[i] = 32'(4 * i);
        compare_log("R5");
    endtask

    // R9: branch held through a stall, and branch noise with empty execute
    task automatic t_branch_gating;
        start(1'b0, 32'h8, 32'h100, NONE, 0, 1'b0);
        do begin @(posedge clk); #1; end while (!(ex_valid && ex_addr == 32'h8));
        stall = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(imem_addr == 32'h10, "R9", "no redirect while stalled", imem_addr, 32'h10);
        stall = 1'b0;
        @(posedge clk); #1;
        chk(imem_addr == 32'h100, "R9", "redirect after stall", imem_addr, 32'h100);
        repeat (5) @(posedge clk);
        exp_n = 5;
        exp_a[0] = 32'h0; exp_a[1] = 32'h4; exp_a[2] = 32'h8;
        exp_a[3] = 32'h100; exp_a[4] = 32'h104;
        compare_log("R9");
        start(1'b0, 32'h8, 32'h100, NONE, 0, 1'b1);
        repeat (10) @(posedge clk);
        compare_log("R9");
    endtask

    initial begin
        bsrc[0] = NONE; bsrc[1] = NONE; bdst[0] = 0; bdst[1] = 0;
        t_reset();
        t_straight();
        t_normal_branch();
        t_delay_branch();
        t_slot_branch();
        t_stall();
        t_branch_gating();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule